// File: doc/BRIEF.md
# Operand-Size-Aware ALU with Condition Flags

This block is the arithmetic stage of a processor datapath that works on three operand sizes: 8, 16 and 32 bits. The caller presents a destination operand, a source operand, an operation and a size, then pulses `start`. One clock later the block gives a registered result and an updated five-bit condition flag register. The flags feed the branch logic that follows the block.

The supported operations are add, subtract, compare, a left shift by one, a left rotate by one through the extend flag, and a two-digit packed decimal add. Every flag is worked out from the active size only. The result replaces only the low bits of the destination that fall inside that size. The bits above the size pass through from `dst` untouched. This lets a narrow operation update part of a wide register.

The extend flag is kept apart from the carry flag. Add, subtract and shift set it to match carry. Compare does not touch it. The rotate and the decimal add read it as an input bit, which lets multi-precision sequences chain through it.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `ccr` is 0 and `res_valid` is 0.
- R2: The operation codes are add=0, subtract=1, compare=2, shift-left=3, rotate-left-through-extend=4 and decimal-add=5. The size codes are 8-bit=0, 16-bit=1 and 32-bit=2. A legal `start` gives `result`, `ccr` and a one-cycle `res_valid` on the next clock edge.
- R3: `ccr` bit 4 is X, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. For every operation except decimal-add, N is the top bit of the result at the selected size, and Z is 1 exactly when every result bit within that size is 0.
- R4: The result bits above the selected size are copied from `dst`. Compare writes no result, so `result` becomes `dst` unchanged.
- R5: Add computes dst+src. C is the carry out of the size's top bit, and X equals C. V is set when both operands have the same sign and the sum has the other sign.
- R6: Subtract computes dst−src. C is the borrow and X equals C. V is set when the operands' signs differ and the difference's sign differs from the sign of dst.
- R7: Compare sets N, Z, V and C exactly as subtract does and leaves X unchanged.
- R8: Shift-left moves dst left by one bit and puts 0 into bit 0. C and X take the bit shifted out of the top. V is set when the top bit changes value.
- R9: Rotate-left moves the old X into bit 0. C and X take the bit leaving the top, and V is cleared.
- R10: Decimal-add always works on the low byte, whatever the size code. It adds two packed two-digit decimal bytes plus X. C and X are set when the decimal sum is above 99, and the byte holds the sum modulo 100.
- R11: Decimal-add clears Z when its byte result is nonzero and otherwise leaves Z as it was. N and V keep their values.
- R12: A `start` with operation code 6 or 7, or with size code 3, is ignored: `res_valid` stays low and `result` and `ccr` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for one operation |
| op | input | 3 | Operation code |
| size | input | 2 | Operand size code |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand and merge base |
| result | output | 32 | Registered merged result |
| res_valid | output | 1 | Pulses one cycle after a legal start |
| ccr | output | 5 | Registered flags X,N,Z,V,C |

## Verification
Directed vectors separate carry from overflow:
- 0xFF+0xFF sets carry without overflow.
- 0x41+0x46 sets overflow without carry.
- The subtraction pairs 0x12−0x34, 0x41−0x87 and 0x95−0x7F tell borrow apart from sign overflow.

Destinations with nonzero upper bits and a zero low field show that Z and the merge use only the active size.

A chain of decimal adds checks three things: that the extend bit feeds the next step, that Z stays sticky, and that a carry out appears at exactly 100.

A long run of random operations, sizes and operands, checked against an independent arithmetic model, covers the interaction between sizes and flag history.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_CMP  = 3'd2,
      OP_ASL  = 3'd3,
      OP_ROXL = 3'd4,
      OP_ABCD = 3'd5
   } alu_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } alu_size_e;

   // Bit order of this struct is the flag register layout: X N Z V C.
   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] top_bit,
   input  logic              sub,
   output logic [DATA_W-1:0] res,
   output logic              carry,
   output logic              ovf
);

   logic [DATA_W:0] wide;
   logic            a_sign, b_sign, r_sign;

   always_comb begin
      if (sub) wide = {1'b0, a & mask} - {1'b0, b & mask};
      else     wide = {1'b0, a & mask} + {1'b0, b & mask};
      res    = wide[DATA_W-1:0] & mask;
      // the bit just above the active MSB is the carry (add) or borrow (sub)
      carry  = |(wide[DATA_W:1] & top_bit);
      a_sign = |(a & top_bit);
      b_sign = |(b & top_bit);
      r_sign = |(res & top_bit);
      if (sub) ovf = (a_sign != b_sign) && (r_sign != a_sign);
      else     ovf = (a_sign == b_sign) && (r_sign != a_sign);
   end

endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] top_bit,
   input  logic              x_in,
   input  logic              rotate,
   output logic [DATA_W-1:0] res,
   output logic              out_bit,
   output logic              ovf
);

   logic [DATA_W-1:0] moved;

   always_comb begin
      moved   = {a[DATA_W-2:0], rotate & x_in};
      res     = moved & mask;
      out_bit = |(a & top_bit);
      ovf     = rotate ? 1'b0 : (out_bit ^ (|(res & top_bit)));
   end

endmodule

// File: rtl/flag_alu_bcd.sv
module flag_alu_bcd #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] b,
   input  logic              x_in,
   output logic [BYTE_W-1:0] sum,
   output logic              carry
);

   localparam int NIB_W = BYTE_W / 2;
   localparam int RAW_W = NIB_W + 1;
   localparam logic [RAW_W-1:0] RADIX = RAW_W'(10);

   logic [RAW_W-1:0] lo_raw, hi_raw, lo_fix, hi_fix;
   logic             lo_c;

   always_comb begin
      lo_raw = RAW_W'(a[NIB_W-1:0]) + RAW_W'(b[NIB_W-1:0]) + RAW_W'(x_in);
      lo_c   = lo_raw >= RADIX;
      lo_fix = lo_c ? (lo_raw - RADIX) : lo_raw;
      hi_raw = RAW_W'(a[BYTE_W-1:NIB_W]) + RAW_W'(b[BYTE_W-1:NIB_W]) + RAW_W'(lo_c);
      carry  = hi_raw >= RADIX;
      hi_fix = carry ? (hi_raw - RADIX) : hi_raw;
      sum    = {hi_fix[NIB_W-1:0], lo_fix[NIB_W-1:0]};
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int         DATA_W  = 32,
   parameter int         WORD_W  = 16,
   parameter int         BYTE_W  = 8,
   parameter bit         BCD_EN  = 1'b1,
   parameter logic [4:0] CCR_RST = 5'b00000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   output logic [DATA_W-1:0] result,
   output logic              res_valid,
   output logic [4:0]        ccr
);

   localparam logic [DATA_W-1:0] MASK_B = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
   localparam logic [DATA_W-1:0] MASK_W = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
   localparam logic [DATA_W-1:0] MASK_L = {DATA_W{1'b1}};

   if (BYTE_W != 8) begin : g_chk_byte
      $error("flag_alu: BYTE_W must be 8 for two packed decimal digits");
   end
   if (!(WORD_W > BYTE_W && DATA_W > WORD_W)) begin : g_chk_order
      $error("flag_alu: sizes must satisfy BYTE_W < WORD_W < DATA_W");
   end

   ccr_t              ccr_q, ccr_nx;
   logic [DATA_W-1:0] res_q, res_nx;
   logic              valid_q;

   logic              legal_op, legal_size, go, is_bcd;
   logic [DATA_W-1:0] eff_mask, top_bit, unit_res;

   logic [DATA_W-1:0] as_res, sh_res;
   logic              as_carry, as_ovf, sh_out, sh_ovf;
   logic [BYTE_W-1:0] bcd_sum;
   logic              bcd_carry;
   logic              n_new, z_new;

   // decode and size mask
   always_comb begin
      is_bcd     = (op == OP_ABCD);
      legal_size = (size != 2'd3);
      legal_op   = (op <= OP_ROXL) || (is_bcd && BCD_EN);
      go         = start && legal_op && legal_size;
      case (size)
         SZ_BYTE: eff_mask = MASK_B;
         SZ_WORD: eff_mask = MASK_W;
         default: eff_mask = MASK_L;
      endcase
      if (is_bcd) eff_mask = MASK_B;
      top_bit = eff_mask & ~(eff_mask >> 1);
   end

   flag_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a       (dst),
      .b       (src),
      .mask    (eff_mask),
      .top_bit (top_bit),
      .sub     (op != OP_ADD),
      .res     (as_res),
      .carry   (as_carry),
      .ovf     (as_ovf)
   );

   flag_alu_shift #(.DATA_W(DATA_W)) u_shift (
      .a       (dst),
      .mask    (eff_mask),
      .top_bit (top_bit),
      .x_in    (ccr_q.x),
      .rotate  (op == OP_ROXL),
      .res     (sh_res),
      .out_bit (sh_out),
      .ovf     (sh_ovf)
   );

   if (BCD_EN) begin : g_bcd
      flag_alu_bcd #(.BYTE_W(BYTE_W)) u_bcd (
         .a     (dst[BYTE_W-1:0]),
         .b     (src[BYTE_W-1:0]),
         .x_in  (ccr_q.x),
         .sum   (bcd_sum),
         .carry (bcd_carry)
      );
   end else begin : g_no_bcd
      assign bcd_sum   = '0;
      assign bcd_carry = 1'b0;
   end

   // result selection, merge and flag update
   always_comb begin
      case (op)
         OP_ASL, OP_ROXL: unit_res = sh_res;
         OP_ABCD:         unit_res = {{(DATA_W-BYTE_W){1'b0}}, bcd_sum};
         default:         unit_res = as_res;
      endcase
      n_new  = |(unit_res & top_bit);
      z_new  = ((unit_res & eff_mask) == '0);
      ccr_nx = ccr_q;
      res_nx = (dst & ~eff_mask) | (unit_res & eff_mask);
      case (op)
         OP_ADD, OP_SUB: begin
            ccr_nx = '{x: as_carry, n: n_new, z: z_new, v: as_ovf, c: as_carry};
         end
         OP_CMP: begin
            ccr_nx = '{x: ccr_q.x, n: n_new, z: z_new, v: as_ovf, c: as_carry};
            res_nx = dst;
         end
         OP_ASL, OP_ROXL: begin
            ccr_nx = '{x: sh_out, n: n_new, z: z_new, v: sh_ovf, c: sh_out};
         end
         OP_ABCD: begin
            ccr_nx.x = bcd_carry;
            ccr_nx.c = bcd_carry;
            if (!z_new) ccr_nx.z = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q   <= '0;
         ccr_q   <= ccr_t'(CCR_RST);
         valid_q <= 1'b0;
      end else begin
         valid_q <= go;
         if (go) begin
            res_q <= res_nx;
            ccr_q <= ccr_nx;
         end
      end
   end

   assign result    = res_q;
   assign ccr       = ccr_q;
   assign res_valid = valid_q;

   // ---------------- assertions ----------------
   p_issue_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op <= 3'd4 && size <= 2'd2) |=> res_valid)
      else $error("p_issue_latency_r2");

   p_byte_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op <= 3'd4 && size == 2'd0) |=>
         result[DATA_W-1:BYTE_W] == $past(dst[DATA_W-1:BYTE_W]))
      else $error("p_byte_merge_r4");

   p_add_x_eq_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd0 && size <= 2'd2) |=> (ccr[4] == ccr[0]))
      else $error("p_add_x_eq_c_r5");

   p_cmp_keeps_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd2 && size <= 2'd2) |=>
         (ccr[4] == $past(ccr[4])) && (result == $past(dst)))
      else $error("p_cmp_keeps_x_r7");

   p_rotate_v_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd4 && size <= 2'd2) |=> !ccr[1])
      else $error("p_rotate_v_clear_r9");

   p_bcd_n_v_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd5 && size <= 2'd2) |=>
         (ccr[3] == $past(ccr[3])) && (ccr[1] == $past(ccr[1])) &&
         !(ccr[2] && !$past(ccr[2])))
      else $error("p_bcd_n_v_kept_r11");

   p_ignore_illegal_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op >= 3'd6 || size == 2'd3)) |=>
         !res_valid && $stable(ccr) && $stable(result))
      else $error("p_ignore_illegal_r12");

endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] res;
      logic [4:0]  flags;
      string       tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = '0;
   logic [1:0]  size = '0;
   logic [31:0] src = '0;
   logic [31:0] dst = '0;
   logic [31:0] result;
   logic        res_valid;
   logic [4:0]  ccr;

   int          errors = 0;
   int          checks = 0;
   exp_item_t   sb_q[$];
   logic [4:0]  exp_ccr = 5'b0;
   logic [31:0] exp_res = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flag_alu dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op        (op),
      .size      (size),
      .src       (src),
      .dst       (dst),
      .result    (result),
      .res_valid (res_valid),
      .ccr       (ccr)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // independent reference model, written from the requirements
   function automatic void model(input logic [2:0] o, input logic [1:0] sz,
                                 input logic [31:0] s, input logic [31:0] d,
                                 input logic [4:0] cin,
                                 output logic [31:0] r_o, output logic [4:0] c_o);
      longint m, sg, a, b, r, da, db, t;
      int     nb;
      bit     x, n, z, v, c;
      {x, n, z, v, c} = cin;
      nb = (o == 3'd5 || sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      m  = (longint'(1) << nb) - 1;
      sg = longint'(1) << (nb - 1);
      a  = longint'(d) & m;
      b  = longint'(s) & m;
      r  = 0;
      case (o)
         3'd0: begin
            t = a + b; r = t & m; c = (t > m);
            v = ((a & sg) == (b & sg)) && ((r & sg) != (a & sg)); x = c;
         end
         3'd1, 3'd2: begin
            t = a - b; r = t & m; c = (a < b);
            v = ((a & sg) != (b & sg)) && ((r & sg) != (a & sg));
            if (o == 3'd1) x = c;
         end
         3'd3: begin
            r = (a << 1) & m; c = (a & sg) != 0;
            v = ((a & sg) != 0) != ((r & sg) != 0); x = c;
         end
         3'd4: begin
            r = ((a << 1) | longint'(x)) & m; c = (a & sg) != 0; v = 0; x = c;
         end
         default: begin
            da = (a >> 4) * 10 + (a & 15);
            db = (b >> 4) * 10 + (b & 15);
            t  = da + db + longint'(x);
            c  = t > 99; x = c;
            t  = t % 100;
            r  = ((t / 10) << 4) | (t % 10);
            if (r != 0) z = 0;
         end
      endcase
      if (o != 3'd5) begin
         n = (r & sg) != 0;
         z = (r == 0);
      end
      if (o == 3'd2) r_o = d;
      else           r_o = (d & ~m[31:0]) | r[31:0];
      c_o = {x, n, z, v, c};
   endfunction

   // driver: called at a falling edge, returns at the next falling edge
   task automatic issue(input logic [2:0] o, input logic [1:0] sz,
                        input logic [31:0] s, input logic [31:0] d, input string tag);
      exp_item_t it;
      if (o <= 3'd5 && sz != 2'd3) begin
         model(o, sz, s, d, exp_ccr, it.res, it.flags);
         it.tag  = tag;
         exp_ccr = it.flags;
         exp_res = it.res;
         sb_q.push_back(it);
      end
      op = o; size = sz; src = s; dst = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // monitor: compares outputs one cycle after each issue
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb_q.size() == 0) begin
            chk("R12", "unexpected res_valid", 32'd1, 32'd0);
         end else begin
            exp_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, "result", result, it.res);
            chk(it.tag, "ccr", {27'd0, ccr}, {27'd0, it.flags});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset result", result, 32'd0);
      chk("R1", "reset ccr", {27'd0, ccr}, 32'd0);
      chk("R1", "reset valid", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // add: carry without overflow, overflow without carry (R5), N/Z (R3)
      issue(3'd0, 2'd0, 32'h0000_00FF, 32'hABCD_12FF, "R5");
      issue(3'd0, 2'd0, 32'h0000_0046, 32'h0000_0041, "R5");
      issue(3'd0, 2'd0, 32'h0000_009F, 32'h0000_00DE, "R5");
      issue(3'd0, 2'd1, 32'h0000_0001, 32'h1234_FFFF, "R3");
      issue(3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, "R5");
      // subtract: borrow and both overflow directions (R6)
      issue(3'd1, 2'd0, 32'h0000_0034, 32'h0000_0012, "R6");
      issue(3'd1, 2'd0, 32'h0000_0087, 32'h0000_0041, "R6");
      issue(3'd1, 2'd0, 32'h0000_007F, 32'h0000_0095, "R6");
      issue(3'd1, 2'd1, 32'h0000_0064, 32'h5555_0000, "R6");
      // merge with zero low field, upper bits nonzero (R4, R3)
      issue(3'd1, 2'd0, 32'h0000_0010, 32'hFFFF_FF10, "R4");
      issue(3'd0, 2'd1, 32'h0000_8000, 32'h8765_8000, "R4");
      // compare keeps X and result (R7)
      issue(3'd0, 2'd0, 32'h0000_0001, 32'h0000_00FF, "R5");
      issue(3'd2, 2'd0, 32'h0000_0001, 32'h0000_0005, "R7");
      issue(3'd2, 2'd2, 32'h0000_0005, 32'h0000_0001, "R7");
      // shift and rotate (R8, R9)
      issue(3'd3, 2'd0, 32'h0, 32'h0000_0081, "R8");
      issue(3'd3, 2'd0, 32'h0, 32'h0000_0040, "R8");
      issue(3'd3, 2'd1, 32'h0, 32'hFFFF_C000, "R8");
      issue(3'd4, 2'd0, 32'h0, 32'h0000_0080, "R9");
      issue(3'd4, 2'd0, 32'h0, 32'h0000_0000, "R9");
      issue(3'd4, 2'd2, 32'h0, 32'h8000_0001, "R9");
      // decimal chain: carry at 100, sticky Z, N and V kept (R10, R11)
      issue(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, "R3");
      issue(3'd5, 2'd2, 32'h0000_0054, 32'hAAAA_AA45, "R10");
      issue(3'd5, 2'd0, 32'h0000_0030, 32'h0000_0012, "R11");
      issue(3'd5, 2'd1, 32'h0000_0049, 32'h0000_0050, "R10");
      issue(3'd5, 2'd0, 32'h0000_0001, 32'h0000_0099, "R11");
      issue(3'd5, 2'd0, 32'h0000_0000, 32'h0000_0000, "R11");
      issue(3'd0, 2'd0, 32'h0000_0081, 32'h0000_0080, "R3");

      // ignored starts (R12): state checked through the ports
      issue(3'd6, 2'd0, 32'h1, 32'hFFFF_FFFF, "R12");
      issue(3'd7, 2'd1, 32'h2, 32'h1234_5678, "R12");
      issue(3'd0, 2'd3, 32'h3, 32'h0000_0001, "R12");
      chk("R12", "result after ignored", result, exp_res);
      chk("R12", "ccr after ignored", {27'd0, ccr}, {27'd0, exp_ccr});

      // random operations (R2 and all flag rules)
      for (int i = 0; i < 400; i++) begin
         logic [2:0]  o;
         logic [31:0] s, d;
         o = 3'($urandom_range(0, 5));
         s = $urandom();
         d = $urandom();
         if (o == 3'd5) begin
            s[7:0] = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            d[7:0] = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
         end
         if (i % 7 == 0) s = d;
         issue(o, 2'($urandom_range(0, 2)), s, d, "R2");
      end

      @(negedge clk);
      chk("R2", "scoreboard drained", sb_q.size(), 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule